// File: doc/BRIEF.md
# Dual-Role Port Mode Switch Controller

This block picks the role of a dual-role port: host, device, or neither. Software drives it through four small registers: a command register that asks for host mode or device mode or drops both roles, a read-only status register, a read-only state register that shows the host and device sub-machines, and a simulate register that selects a short guard interval for simulation runs.

Dropping the roles is never instant. A drop puts both role machines into a wait-for-supply-fail state and starts a guard down-counter. The counter is loaded from one of two parameterised lengths. With simulate bit 0 clear it counts the cycles of one second of real time. With the bit set it counts the 2 to 3 ms fast setting. Neither role can come up while the guard runs. A role request made in that window is remembered and is served when the counter reaches zero. A later drop forgets it. A request for both roles at once is refused and sets a sticky error flag.

After reset the block reports not-ready for a fixed number of cycles and ignores command writes during that time. A granted role spends one cycle in power-up before its ready flag is set.

Top module: `drd_role_ctrl`

## Requirements
- R1: After reset, status bit 0 (not-ready) reads 1 for exactly INIT_CYC clock cycles and then stays 0. Command writes made while it is 1 have no effect.
- R2: Command register address 0 uses bit 0 for host request, bit 1 for device request, bit 2 for drop and bit 3 for error clear. A write with any bit above 3 set is discarded. A host request made with both roles idle and no guard running gives host state 2 (power-up) after the write edge and host state 3 (ready) one cycle later. Status bit 1 is the host-ready flag.
- R3: A device request made under the same conditions follows the same timing on the device machine. Status bit 2 is the device-ready flag.
- R4: A drop moves both machines to state 1 (wait) on its write edge, clears both ready flags and sets status bit 4 (guard busy). With simulate bit 0 clear, the wait lasts GUARD_REAL_CYC cycles.
- R5: With simulate bit 0 set at the drop, the wait lasts GUARD_SIM_CYC cycles.
- R6: A single-role request written during the wait does not raise any ready flag before the wait ends. A later request overrides an earlier one. When the wait ends, the last request moves its machine to power-up and then to ready, and the other machine goes to idle.
- R7: A drop during the wait clears any remembered request and restarts the full wait.
- R8: A command with host and device bits both set (and no drop) grants nothing and sets status bit 3 (error). The error bit stays set until a command write with bit 3 set.
- R9: The state register at address 2 shows the host state in bits 5:3 and the device state in bits 2:0. The codes are 0 idle, 1 wait, 2 power-up, 3 ready.
- R10: A role request made while either role is in power-up or ready is ignored. At most one role is active at a time.
- R11: The simulate register at address 3 stores bit 0 and reads 0 in all other bits. Address 0 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | REG_W | Write data |
| rdata_o | output | REG_W | Read data for addr_i (combinational) |

## Verification
Status and state are read combinationally, so each result is due the cycle after the edge that changes a register. A granted request shows power-up right after its write edge and ready one cycle later. A drop shows wait right after its edge. The wait ends exactly N edges after the drop, so ready comes N+1 edges after the drop when a request is remembered. The bench drives at the falling edge and reads one time unit later. It counts every write as one cycle and every idle step as one cycle, so each vector names the cycle offset at which it samples, including the last wait cycle and the first cycle after the wait.

// File: rtl/drd_role_pkg.sv
package drd_role_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_VBUS_WAIT = 3'd1,
    ST_PWRUP     = 3'd2,
    ST_READY     = 3'd3
  } role_st_e;

  localparam logic [1:0] ADDR_CMD   = 2'd0;
  localparam logic [1:0] ADDR_STAT  = 2'd1;
  localparam logic [1:0] ADDR_STATE = 2'd2;
  localparam logic [1:0] ADDR_SIM   = 2'd3;

  localparam int unsigned CMD_HOST = 0;
  localparam int unsigned CMD_DEV  = 1;
  localparam int unsigned CMD_DROP = 2;
  localparam int unsigned CMD_CLR  = 3;
  localparam int unsigned CMD_BITS = 4;

  localparam int unsigned STS_NRDY = 0;
  localparam int unsigned STS_HRDY = 1;
  localparam int unsigned STS_DRDY = 2;
  localparam int unsigned STS_ERR  = 3;
  localparam int unsigned STS_BUSY = 4;
endpackage

// File: rtl/drd_init_gate.sv
module drd_init_gate #(
  parameter int unsigned INIT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic nrdy_o
);
  localparam int unsigned CW = $clog2(INIT_CYC + 2);
  localparam logic [CW-1:0] INIT_V = CW'(INIT_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q != INIT_V) cnt_q <= cnt_q + 1'b1;
  end

  assign nrdy_o = (cnt_q != INIT_V);

  p_ready_stays_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nrdy_o |=> !nrdy_o);
endmodule

// File: rtl/drd_guard_timer.sv
module drd_guard_timer #(
  parameter int unsigned REAL_CYC = 100_000_000,
  parameter int unsigned SIM_CYC  = 250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic fast_i,
  output logic busy_o,
  output logic expire_o
);
  localparam int unsigned MAX_CYC = (REAL_CYC > SIM_CYC) ? REAL_CYC : SIM_CYC;
  localparam int unsigned CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] REAL_V = CW'(REAL_CYC);
  localparam logic [CW-1:0] SIM_V  = CW'(SIM_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= fast_i ? SIM_V : REAL_V;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o   = (cnt_q != '0);
  assign expire_o = (cnt_q == CW'(1));

  p_expire_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !load_i |=> !busy_o);
  p_load_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o);
endmodule

// File: rtl/drd_role_fsm.sv
module drd_role_fsm
  import drd_role_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     drop_i,
  input  logic     grant_i,
  input  logic     expire_i,
  input  logic     pend_i,
  output role_st_e st_o
);
  role_st_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE:      if (grant_i) st_n = ST_PWRUP;
      ST_VBUS_WAIT: if (expire_i) st_n = pend_i ? ST_PWRUP : ST_IDLE;
      ST_PWRUP:     st_n = ST_READY;
      ST_READY:     st_n = ST_READY;
      default:      st_n = ST_IDLE;
    endcase
    if (drop_i) st_n = ST_VBUS_WAIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_n;
  end

  assign st_o = st_q;

  p_pwrup_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_PWRUP && !drop_i |=> st_q == ST_READY);
  p_wait_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_VBUS_WAIT && !expire_i |=> st_q == ST_VBUS_WAIT);
  p_drop_enters_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> st_q == ST_VBUS_WAIT);
endmodule

// File: rtl/drd_cmd_regs.sv
module drd_cmd_regs
  import drd_role_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             nrdy_i,
  input  logic             busy_i,
  input  logic             expire_i,
  input  role_st_e         host_st_i,
  input  role_st_e         dev_st_i,
  output logic             drop_o,
  output logic             host_grant_o,
  output logic             dev_grant_o,
  output logic             host_pend_o,
  output logic             dev_pend_o,
  output logic             fast_o,
  output logic [REG_W-1:0] rdata_o
);
  logic cmd_wr, rsvd_set, req_h, req_d, conflict, clr, quiet;
  logic ph_q, pd_q, err_q, fast_q;
  logic [REG_W-1:0] sts_w, state_w;

  assign rsvd_set = |wdata_i[REG_W-1:CMD_BITS];
  assign cmd_wr   = wr_en_i && addr_i == ADDR_CMD && !nrdy_i && !rsvd_set;
  assign drop_o   = cmd_wr && wdata_i[CMD_DROP];
  assign req_h    = cmd_wr && !wdata_i[CMD_DROP] && wdata_i[CMD_HOST] && !wdata_i[CMD_DEV];
  assign req_d    = cmd_wr && !wdata_i[CMD_DROP] && wdata_i[CMD_DEV] && !wdata_i[CMD_HOST];
  assign conflict = cmd_wr && !wdata_i[CMD_DROP] && wdata_i[CMD_DEV] && wdata_i[CMD_HOST];
  assign clr      = cmd_wr && wdata_i[CMD_CLR];
  assign quiet    = host_st_i == ST_IDLE && dev_st_i == ST_IDLE && !busy_i;

  assign host_grant_o = req_h && quiet;
  assign dev_grant_o  = req_d && quiet;
  // newest request during the wait wins, also on the expiry edge itself
  assign host_pend_o  = (req_h && busy_i) || (ph_q && !(req_d && busy_i));
  assign dev_pend_o   = (req_d && busy_i) || (pd_q && !(req_h && busy_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= 1'b0;
      pd_q <= 1'b0;
    end else if (drop_o || expire_i) begin
      ph_q <= 1'b0;
      pd_q <= 1'b0;
    end else if (busy_i && (req_h || req_d)) begin
      ph_q <= req_h;
      pd_q <= req_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= 1'b0;
    else if (conflict) err_q <= 1'b1;
    else if (clr)      err_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           fast_q <= 1'b0;
    else if (wr_en_i && addr_i == ADDR_SIM) fast_q <= wdata_i[0];
  end

  assign fast_o = fast_q;

  always_comb begin
    sts_w = '0;
    sts_w[STS_NRDY] = nrdy_i;
    sts_w[STS_HRDY] = host_st_i == ST_READY;
    sts_w[STS_DRDY] = dev_st_i == ST_READY;
    sts_w[STS_ERR]  = err_q;
    sts_w[STS_BUSY] = busy_i;
    state_w = '0;
    state_w[5:3] = host_st_i;
    state_w[2:0] = dev_st_i;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_STAT:  rdata_o = sts_w;
      ADDR_STATE: rdata_o = state_w;
      ADDR_SIM:   rdata_o = {{(REG_W-1){1'b0}}, fast_q};
      default:    rdata_o = '0;
    endcase
  end

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !clr |=> err_q);
  p_no_dual_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ph_q && pd_q));
  p_drop_forgets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> !ph_q && !pd_q);
endmodule

// File: rtl/drd_role_ctrl.sv
module drd_role_ctrl
  import drd_role_pkg::*;
#(
  parameter int unsigned REG_W          = 8,
  parameter int unsigned INIT_CYC       = 16,
  parameter int unsigned GUARD_REAL_CYC = 100_000_000,
  parameter int unsigned GUARD_SIM_CYC  = 250_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o
);
  localparam int unsigned N_ROLE = 2;

  logic nrdy, busy, expire, drop, fast;
  logic [N_ROLE-1:0] grant, pend;
  role_st_e st [N_ROLE];

  drd_init_gate #(.INIT_CYC(INIT_CYC)) u_init (
    .clk_i(clk_i), .rst_ni(rst_ni), .nrdy_o(nrdy)
  );

  drd_guard_timer #(.REAL_CYC(GUARD_REAL_CYC), .SIM_CYC(GUARD_SIM_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(drop), .fast_i(fast),
    .busy_o(busy), .expire_o(expire)
  );

  drd_cmd_regs #(.REG_W(REG_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .nrdy_i(nrdy), .busy_i(busy), .expire_i(expire),
    .host_st_i(st[0]), .dev_st_i(st[1]), .drop_o(drop),
    .host_grant_o(grant[0]), .dev_grant_o(grant[1]),
    .host_pend_o(pend[0]), .dev_pend_o(pend[1]),
    .fast_o(fast), .rdata_o(rdata_o)
  );

  // index 0 = host, 1 = device
  for (genvar g = 0; g < N_ROLE; g++) begin : g_role
    drd_role_fsm u_fsm (
      .clk_i(clk_i), .rst_ni(rst_ni), .drop_i(drop), .grant_i(grant[g]),
      .expire_i(expire), .pend_i(pend[g]), .st_o(st[g])
    );
  end

  p_single_role_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((st[0] == ST_PWRUP || st[0] == ST_READY) && (st[1] == ST_PWRUP || st[1] == ST_READY)));
  p_wait_tracks_timer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st[0] == ST_VBUS_WAIT) == busy);
  p_ready_after_guard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st[0] == ST_READY || st[1] == ST_READY) |-> !busy);
  p_nrdy_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nrdy |-> st[0] == ST_IDLE && st[1] == ST_IDLE);
endmodule

// File: tb/drd_role_ctrl_test.sv
module drd_role_ctrl_test;
  localparam int CLK_P  = 10;
  localparam int W      = 8;
  localparam int INIT   = 5;
  localparam int G_REAL = 40;
  localparam int G_SIM  = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd1;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  drd_role_ctrl #(.REG_W(W), .INIT_CYC(INIT), .GUARD_REAL_CYC(G_REAL),
                  .GUARD_SIM_CYC(G_SIM)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  typedef struct packed {
    logic       wr;
    logic [1:0] adr;
    logic [7:0] dat;
    logic [7:0] dly;
    logic [7:0] sts;
    logic [7:0] ste;
  } vec_t;

  // status: b0 nrdy b1 hrdy b2 drdy b3 err b4 busy; state: host[5:3] dev[2:0]
  localparam vec_t VECS [0:13] = '{
    '{1'b1, 2'd0, 8'h01, 8'd0, 8'h00, 8'h10},           // R2 host grant -> power-up
    '{1'b0, 2'd0, 8'h00, 8'd1, 8'h02, 8'h18},           // R2 R9 host ready
    '{1'b1, 2'd0, 8'h02, 8'd2, 8'h02, 8'h18},           // R10 device req ignored
    '{1'b1, 2'd0, 8'h04, 8'd0, 8'h10, 8'h09},           // R4 drop -> both wait
    '{1'b1, 2'd0, 8'h02, 8'd0, 8'h10, 8'h09},           // R6 device req during wait
    '{1'b0, 2'd0, 8'h00, 8'(G_REAL-2), 8'h10, 8'h09},   // R4 last wait cycle
    '{1'b0, 2'd0, 8'h00, 8'd1, 8'h00, 8'h02},           // R4 R6 wait over, device power-up
    '{1'b0, 2'd0, 8'h00, 8'd1, 8'h04, 8'h03},           // R3 device ready
    '{1'b1, 2'd3, 8'h01, 8'd0, 8'h04, 8'h03},           // R11 simulate write no role effect
    '{1'b1, 2'd0, 8'h04, 8'd0, 8'h10, 8'h09},           // R5 drop with fast guard
    '{1'b1, 2'd0, 8'h01, 8'd0, 8'h10, 8'h09},           // R6 host req during wait
    '{1'b0, 2'd0, 8'h00, 8'(G_SIM-2), 8'h10, 8'h09},    // R5 last wait cycle
    '{1'b0, 2'd0, 8'h00, 8'd1, 8'h00, 8'h10},           // R5 host power-up
    '{1'b0, 2'd0, 8'h00, 8'd1, 8'h02, 8'h18}            // R6 host ready
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [W-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic both(input string req, input logic [W-1:0] es, input logic [W-1:0] et);
    logic [W-1:0] v;
    peek(2'd1, v); chk(req, v, es);
    peek(2'd2, v); chk(req, v, et);
  endtask

  initial begin
    logic [W-1:0] v;
    int n;
    tick(3);
    rst_ni = 1'b1;
    both("R1 reset", 8'h01, 8'h00);
    wr(2'd0, 8'h01);                     // ignored while not ready
    both("R1 cmd ignored", 8'h01, 8'h00);
    n = 0;
    peek(2'd1, v);
    while (v[0] && n < 50) begin
      tick(1); n++;
      peek(2'd1, v);
    end
    chk("R1 not-ready length", W'(1 + n), W'(INIT));
    both("R1 after init", 8'h00, 8'h00);

    // R2 reserved bits discard the command
    wr(2'd0, 8'h11);
    tick(1);
    both("R2 reserved bits", 8'h00, 8'h00);

    for (int i = 0; i < 14; i++) begin
      if (VECS[i].wr) wr(VECS[i].adr, VECS[i].dat);
      tick(int'(VECS[i].dly));
      both($sformatf("vector %0d (R2..R10)", i), VECS[i].sts, VECS[i].ste);
    end

    // R7: second drop clears remembered host request and restarts wait
    wr(2'd0, 8'h04);
    wr(2'd0, 8'h01);
    tick(3);
    wr(2'd0, 8'h04);
    tick(G_SIM - 1);
    both("R7 restarted wait", 8'h10, 8'h09);
    tick(1);
    both("R7 wait over idle", 8'h00, 8'h00);
    tick(1);
    both("R7 request forgotten", 8'h00, 8'h00);

    // R8: both roles at once
    wr(2'd0, 8'h03);
    both("R8 conflict", 8'h08, 8'h00);
    tick(1);
    both("R8 nothing granted", 8'h08, 8'h00);
    wr(2'd0, 8'h01);
    tick(1);
    both("R8 error sticky", 8'h0A, 8'h18);
    wr(2'd0, 8'h08);
    both("R8 error cleared", 8'h02, 8'h18);

    // R11
    wr(2'd3, 8'hFF);
    peek(2'd3, v); chk("R11 simulate readback", v, 8'h01);
    peek(2'd0, v); chk("R11 command reads zero", v, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule